// File: doc/BRIEF.md
# Programmable Bus Memory Cycle Timer

This block times one memory access on an ISA-style expansion bus. It runs from a 20 MHz clock, so one clock is 50 ns. When a request is seen, it drives the memory strobe for a programmable number of clocks, the active phase. It then holds the bus quiet for a recovery period. Only after that does it start the next access. A busy flag covers both phases. A one-clock done marker flags the last strobe clock.

Two settings fix the timing, and both live in a small configuration register that is written through a write-enable port. The first is a 3-bit strobe length code N, which gives N+1 clocks of strobe. The second is a 1-bit recovery select that picks a long (200 ns) or short (100 ns) recovery. A cycle that is already running keeps the settings it started with.

A request that comes in while a cycle runs is held and is not lost. Several such requests merge into one. The held request starts on the same clock edge that ends recovery, so no dead clock is added between cycles.

Top module: `mem_cycle_timer`

## Requirements
- R1: While and right after synchronous reset (rst_n low), strobe_o, busy_o and done_o are all low.
- R2: With the block idle, a high req_i sampled at a rising edge makes strobe_o high for exactly N+1 clock periods starting at that edge, where N is the 3-bit strobe length code.
- R3: After reset the register holds N = 4 and recovery select = 0, so one request gives a 5-clock strobe (250 ns) followed by a 4-clock recovery (200 ns).
- R4: Recovery select 0 gives a 4-clock recovery and select 1 gives a 2-clock recovery. During recovery busy_o is high and strobe_o is low.
- R5: done_o is high for exactly one clock per cycle, namely the last clock in which strobe_o is high.
- R6: When cfg_wr_i is high at a rising edge, cfg_active_i (N) and cfg_idle_short_i (recovery select) are stored. A cycle already running finishes with the N and recovery select it started with.
- R7: A high req_i sampled while busy_o is high is held (one deep, so repeats merge) and starts a new strobe on the edge that ends recovery, with no idle clock in between. A request sampled on that final edge also starts at once.
- R8: When recovery ends and no request is held or present, busy_o falls and stays low until a new request.
- R9: N = 0 gives a one-clock strobe, with done_o high in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per 50 ns step |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Memory cycle request, sampled every rising edge |
| cfg_wr_i | input | 1 | Write enable for the configuration register |
| cfg_active_i | input | 3 | Strobe length code N (strobe lasts N+1 clocks) |
| cfg_idle_short_i | input | 1 | Recovery select: 0 = 4 clocks, 1 = 2 clocks |
| strobe_o | output | 1 | Memory strobe, high during the active phase |
| busy_o | output | 1 | High from the start of the strobe to the end of recovery |
| done_o | output | 1 | One-clock marker on the last strobe clock |

## Verification
Two events can fall on the same clock edge: the end of recovery and the start of the next cycle, which comes from a held request or from a request seen on that very edge. The bench provokes this in three ways. It places a request inside the strobe, it places requests that repeat through recovery, and it times one request to land exactly on the final recovery edge. In each case the total busy span must equal two full cycles with no gap. A configuration write landing in the middle of a strobe is the other overlap. It is judged by the width of that strobe and the length of its recovery, and then by the next cycle, which must use the new values.

// File: rtl/mct_pkg.sv
// Package: shared types for the memory cycle timer.
// Assumes: nothing beyond IEEE 1800-2017.
package mct_pkg;

    // Phase of one bus memory cycle
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

endpackage

// File: rtl/mct_cfg_reg.sv
// Module: configuration register for strobe length and recovery select.
// Assumes: writes come as single-cycle enables; values hold between writes.
module mct_cfg_reg #(
    parameter int          ACT_W   = 3,
    parameter logic [ACT_W-1:0] ACT_RST = 3'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ACT_W-1:0] act_in,
    input  logic             short_in,
    output logic [ACT_W-1:0] act_q,
    output logic             short_q
);

    // Store the settings on a write; reset to the default timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= ACT_RST;
            short_q <= 1'b0;
        end else if (wr_en) begin
            act_q   <= act_in;
            short_q <= short_in;
        end
    end

    // R6: the register changes only when written
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(act_q) && $stable(short_q)));

endmodule

// File: rtl/mct_req_hold.sv
// Module: one-deep holder for requests that arrive while a cycle runs.
// Assumes: launch marks the edge on which the sequencer starts a cycle.
module mct_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic launch,
    output logic pending
);

    // Set on a request while busy, clear when a cycle is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (launch) begin
            pending <= 1'b0;
        end else if (req && busy) begin
            pending <= 1'b1;
        end
    end

    // R7: a held request is never dropped before it is launched
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !launch) |=> pending);

endmodule

// File: rtl/mct_cycle_fsm.sv
// Module: phase sequencer and shared down-counter for one memory cycle.
// Assumes: IDLE_SHORT >= 1 and IDLE_LONG >= IDLE_SHORT; recovery choice is
// captured at launch so mid-cycle register writes do not disturb it.
module mct_cycle_fsm #(
    parameter int ACT_W      = 3,
    parameter int IDLE_LONG  = 4,
    parameter int IDLE_SHORT = 2,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [ACT_W-1:0] act_len,
    input  logic             short_sel,
    output logic             launch,
    output logic             strobe,
    output logic             busy,
    output logic             done
);
    import mct_pkg::*;

    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(IDLE_LONG - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(IDLE_SHORT - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             short_cap;
    logic             last;

    // Decode the final clock of a phase and the launch condition
    always_comb begin
        last   = (cnt == '0);
        launch = start_req &&
                 ((phase == PH_IDLE) || ((phase == PH_RECOVER) && last));
    end

    // Advance the phase and count down the clocks left in it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            short_cap <= 1'b0;
        end else if (launch) begin
            phase     <= PH_ACTIVE;
            cnt       <= CNT_W'(act_len);
            short_cap <= short_sel;
        end else begin
            case (phase)
                PH_ACTIVE: begin
                    if (last) begin
                        phase <= PH_RECOVER;
                        cnt   <= short_cap ? SHORT_LOAD : LONG_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOVER: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Drive the bus-facing flags from the phase
    always_comb begin
        strobe = (phase == PH_ACTIVE);
        busy   = (phase != PH_IDLE);
        done   = strobe && last;
    end

    // R5: the done marker is always followed by recovery
    a_r5_done_then_recover: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (phase == PH_RECOVER));

    // R4: recovery never counts beyond the long setting
    a_r4_recover_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RECOVER) |-> (cnt <= LONG_LOAD));

    // R7: a request at the end of recovery restarts the strobe with no gap
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_RECOVER) && last && start_req) |=> strobe);

    // R8: without a request recovery drops back to idle
    a_r8_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_RECOVER) && last && !start_req) |=> !busy);

endmodule

// File: rtl/mem_cycle_timer.sv
// Module: top of the programmable bus memory cycle timer.
// Assumes: clk period is one timing step (50 ns); reset is synchronous.
module mem_cycle_timer #(
    parameter int                ACT_W      = 3,
    parameter logic [ACT_W-1:0]  ACT_RST    = 3'd4,
    parameter int                IDLE_LONG  = 4,
    parameter int                IDLE_SHORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             cfg_wr_i,
    input  logic [ACT_W-1:0] cfg_active_i,
    input  logic             cfg_idle_short_i,
    output logic             strobe_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int IDLE_W = (IDLE_LONG > 1) ? $clog2(IDLE_LONG) : 1;
    localparam int CNT_W  = (ACT_W > IDLE_W) ? ACT_W : IDLE_W;

    logic [ACT_W-1:0] act_len;
    logic             short_sel;
    logic             pending;
    logic             launch;
    logic             start_req;

    // Merge a live request with a held one
    always_comb begin
        start_req = req_i || pending;
    end

    mct_cfg_reg #(
        .ACT_W   (ACT_W),
        .ACT_RST (ACT_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_i),
        .act_in   (cfg_active_i),
        .short_in (cfg_idle_short_i),
        .act_q    (act_len),
        .short_q  (short_sel)
    );

    mct_req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_i),
        .busy    (busy_o),
        .launch  (launch),
        .pending (pending)
    );

    mct_cycle_fsm #(
        .ACT_W      (ACT_W),
        .IDLE_LONG  (IDLE_LONG),
        .IDLE_SHORT (IDLE_SHORT),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .act_len   (act_len),
        .short_sel (short_sel),
        .launch    (launch),
        .strobe    (strobe_o),
        .busy      (busy_o),
        .done      (done_o)
    );

    // R2: the strobe only rises because of a live or held request
    a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> ($past(req_i) || $past(pending)));

    // R4: strobe is never high outside a busy cycle
    a_r4_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o);

endmodule

// File: tb/tb_mem_cycle_timer.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks on strobe width, recovery length and busy span.
module tb_mem_cycle_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_i;
    logic       cfg_wr_i;
    logic [2:0] cfg_active_i;
    logic       cfg_idle_short_i;
    logic       strobe_o;
    logic       busy_o;
    logic       done_o;

    always #5 clk = ~clk;

    mem_cycle_timer dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_i            (req_i),
        .cfg_wr_i         (cfg_wr_i),
        .cfg_active_i     (cfg_active_i),
        .cfg_idle_short_i (cfg_idle_short_i),
        .strobe_o         (strobe_o),
        .busy_o           (busy_o),
        .done_o           (done_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    armed   = 1'b0;
    string tag     = "R1";

    // Reference model state: phase 0 idle, 1 strobe, 2 recovery
    int m_ph, m_rem, m_pend, m_n, m_s, m_cur;

    // Monitor state
    int run_s = 0, last_width = 0;
    int run_g = 0, last_gap = 0;
    int run_b = 0, last_busy = 0;
    int done_cnt = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model of the timing rules, advanced at each rising edge
    always @(posedge clk) begin : ref_model
        int pre;
        bit st;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_pend = 0; m_n = 4; m_s = 0; m_cur = 4;
        end else begin
            pre = m_ph;
            st  = 1'b0;
            if (m_ph == 0) begin
                if (req_i) st = 1'b1;
            end else if (m_ph == 1) begin
                if (m_rem == 1) begin m_ph = 2; m_rem = m_cur; end
                else m_rem--;
            end else begin
                if (m_rem == 1) begin
                    if (req_i || m_pend != 0) st = 1'b1;
                    else m_ph = 0;
                end else m_rem--;
            end
            if (st) m_pend = 0;
            else if (req_i && pre != 0) m_pend = 1;
            if (st) begin
                m_ph = 1; m_rem = m_n + 1; m_cur = (m_s != 0) ? 2 : 4;
            end
            if (cfg_wr_i) begin m_n = int'(cfg_active_i); m_s = int'(cfg_idle_short_i); end
        end
    end

    // Compare against the model and record run lengths, away from the edge
    always @(negedge clk) begin
        if (armed) begin
            check(strobe_o === (m_ph == 1), {tag, " strobe"}, int'(strobe_o), int'(m_ph == 1));
            check(busy_o === (m_ph != 0), {tag, " busy"}, int'(busy_o), int'(m_ph != 0));
            check(done_o === (m_ph == 1 && m_rem == 1), {tag, " done"},
                  int'(done_o), int'(m_ph == 1 && m_rem == 1));
            if (strobe_o) run_s++;
            else if (run_s != 0) begin last_width = run_s; run_s = 0; end
            if (busy_o && !strobe_o) run_g++;
            else if (run_g != 0) begin last_gap = run_g; run_g = 0; end
            if (busy_o) run_b++;
            else if (run_b != 0) begin last_busy = run_b; run_b = 0; end
            if (done_o) done_cnt++;
        end
    end

    task automatic hold_req(input int n);
        @(posedge clk); #2 req_i = 1'b1;
        repeat (n) @(posedge clk);
        #2 req_i = 1'b0;
    endtask

    task automatic write_cfg(input int n, input bit s);
        @(posedge clk); #2;
        cfg_wr_i = 1'b1; cfg_active_i = 3'(n); cfg_idle_short_i = s;
        @(posedge clk); #2 cfg_wr_i = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_o === 1'b1);
        repeat (2) @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int d0;
        rst_n = 1'b0; req_i = 1'b0; cfg_wr_i = 1'b0;
        cfg_active_i = 3'd0; cfg_idle_short_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(strobe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
              int'({strobe_o, busy_o, done_o}), 0);
        @(posedge clk); #2 rst_n = 1'b1; armed = 1'b1;
        @(negedge clk);
        check({strobe_o, busy_o, done_o} === 3'b000, "R1 after reset",
              int'({strobe_o, busy_o, done_o}), 0);

        // R3 defaults, R2 width, R5 single done
        tag = "R3"; d0 = done_cnt;
        hold_req(1); wait_idle();
        check(last_width == 5, "R2/R3 default strobe width", last_width, 5);
        check(last_gap == 4, "R3 default recovery", last_gap, 4);
        check(done_cnt - d0 == 1, "R5 one done per cycle", done_cnt - d0, 1);

        // R9 shortest strobe, R4 short recovery
        tag = "R9"; write_cfg(0, 1'b1); d0 = done_cnt;
        hold_req(1); wait_idle();
        check(last_width == 1, "R9 one-clock strobe", last_width, 1);
        check(last_gap == 2, "R4 short recovery", last_gap, 2);
        check(done_cnt - d0 == 1, "R9 done with single strobe", done_cnt - d0, 1);

        // R6 mid-cycle write does not disturb the running cycle
        tag = "R6"; write_cfg(2, 1'b0);
        hold_req(1); write_cfg(6, 1'b1); wait_idle();
        check(last_width == 3, "R6 running cycle keeps strobe", last_width, 3);
        check(last_gap == 4, "R6 running cycle keeps recovery", last_gap, 4);
        hold_req(1); wait_idle();
        check(last_width == 7, "R6 new strobe length used", last_width, 7);
        check(last_gap == 2, "R4/R6 new recovery used", last_gap, 2);

        // R7 request during strobe is held and chained with no gap
        tag = "R7"; write_cfg(1, 1'b0);
        hold_req(2); wait_idle();
        check(last_busy == 12, "R7 held request chained", last_busy, 12);

        // R7 repeated requests in recovery merge into one extra cycle
        hold_req(1); hold_req(3); wait_idle();
        check(last_busy == 12, "R7 repeats merge", last_busy, 12);

        // R7 request landing on the final recovery edge
        hold_req(1); repeat (4) @(posedge clk); hold_req(1); wait_idle();
        check(last_busy == 12, "R7 request on last recovery edge", last_busy, 12);

        // R8 no request: stays idle
        tag = "R8";
        repeat (5) begin
            @(negedge clk); #1;
            check(busy_o === 1'b0 && strobe_o === 1'b0, "R8 idle without request",
                  int'({busy_o, strobe_o}), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule